// File: doc/BRIEF.md
# Slot Pool Allocator with Recycled Free List

This block hands out storage slots in a small on-chip data store. It holds a queue of the slot numbers that are currently unused. An allocation request takes the slot number at the head of that queue and writes the request's data word into that slot. The slot number is then returned to the requester. A release request names a slot that is in use and reads back its data word. The slot's entry is then wiped to zero and its number goes to the tail of the free queue, so the slot can be handed out again.

After reset every slot is free and the queue holds the slot numbers in ascending order. Requests that cannot be served are answered on the ports and leave the internal state untouched. That covers an allocation when no slot is free, and a release of a slot that is not in use. Allocation and release can be issued in the same cycle. All responses appear one clock after the request.

Top module: `slot_pool`

## Requirements
- R1: While reset is held and in the first cycle after it, `alloc_ack`, `rel_ack` and `rel_err` are low, `pool_empty` (all slots free) is high and `pool_full` (no slot free) is low.
- R2: An allocation request that finds a free slot is answered one clock later by `alloc_ack` high for one cycle, with `alloc_slot` giving the slot number taken from the head of the free queue. The first SLOTS allocations after reset return 0, 1, 2, ... in ascending order.
- R3: Released slot numbers join the tail of the free queue and are handed out again in the order they were released, after the slot numbers already queued.
- R4: A release request for a slot in use is answered one clock later by `rel_ack` high for one cycle, with `rel_data` holding the word last written into that slot.
- R5: The entry of a released slot is overwritten with zero in the cycle after the release is acknowledged.
- R6: An allocation request while `pool_full` is high is refused. No `alloc_ack` follows and no slot or data changes.
- R7: A release request naming a free slot or a number not below SLOTS is answered one clock later by `rel_err` high and no `rel_ack`, and it changes no state.
- R8: An allocation that lands on a slot whose zero-clear is still pending keeps the newly written data, and the clear is dropped.
- R9: An allocation and a release in the same cycle are both served. A release does not make a slot available to an allocation issued in the same cycle.
- R10: `pool_full` is high exactly when no slot is free, and `pool_empty` is high exactly when every slot is free. Both reflect the requests accepted up to the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alloc_req | input | 1 | Request to allocate a slot and store `alloc_data` |
| alloc_data | input | DATA_W | Data word written into the allocated slot |
| rel_req | input | 1 | Request to release the slot named by `rel_slot` |
| rel_slot | input | IDX_W | Slot number to release |
| alloc_ack | output | 1 | One-cycle pulse: allocation accepted |
| alloc_slot | output | IDX_W | Slot number given by the last accepted allocation |
| rel_ack | output | 1 | One-cycle pulse: release accepted |
| rel_data | output | DATA_W | Data read from the last released slot |
| rel_err | output | 1 | One-cycle pulse: release refused |
| pool_full | output | 1 | No free slot remains |
| pool_empty | output | 1 | All slots are free |

## Verification
The bench builds the block with its defaults: 32 slots and 16-bit data. With these values the pool can be drained completely in a few dozen cycles, so the refusal path and the full flag are reached several times. The same size also makes it cheap to empty the free queue and then release one slot and allocate it again at once. That places an allocation on a slot whose zero-clear is still pending, a case reachable only when the queue had nothing ahead of the released number. A long stretch of random mixed traffic then wraps the queue pointers many times and shuffles the order in which slot numbers come back.

// File: rtl/slot_pool_pkg.sv
package slot_pool_pkg;
  // width of a slot number for a pool of n slots
  function automatic int unsigned slot_bits(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // width of a count that ranges over 0..n
  function automatic int unsigned count_bits(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/slot_free_fifo.sv
module slot_free_fifo #(
  parameter int SLOTS = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pop,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] free_cnt
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] q [SLOTS];
  logic [IDX_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) q[i] <= IDX_W'(i);
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      free_cnt <= CNT_W'(SLOTS);
    end else begin
      if (push) begin
        q[wr_ptr] <= push_idx;
        wr_ptr    <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      free_cnt <= free_cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_idx = q[rd_ptr];

  // R6: never take a slot number from an empty queue
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (free_cnt != '0));

  // R3: a returned number always finds room in the queue
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (free_cnt < CNT_W'(SLOTS)));
endmodule

// File: rtl/slot_busy_map.sv
module slot_busy_map #(
  parameter int SLOTS = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] query_idx,
  output logic             query_busy
);
  logic [SLOTS-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else begin
      if (clr) bits[clr_idx] <= 1'b0;
      if (set) bits[set_idx] <= 1'b1;
    end
  end

  assign query_busy = (32'(query_idx) < 32'(SLOTS)) ? bits[query_idx] : 1'b0;

  // R2: a slot handed out must have been free
  a_r2_fresh_slot: assert property (@(posedge clk) disable iff (rst)
    set |-> !bits[set_idx]);

  // R7: only slots in use are ever released
  a_r7_release_busy: assert property (@(posedge clk) disable iff (rst)
    clr |-> bits[clr_idx]);
endmodule

// File: rtl/slot_store.sv
module slot_store #(
  parameter int SLOTS  = 32,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic              re,
  input  logic [IDX_W-1:0]  r_idx,
  output logic [DATA_W-1:0] r_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx
);
  logic [DATA_W-1:0] mem [SLOTS];
  logic              clr_go;

  // a fresh write to the same slot outranks the delayed wipe
  assign clr_go = clr_en && !(we && (w_idx == clr_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      if (clr_go) mem[clr_idx] <= '0;
      if (we)     mem[w_idx]   <= w_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     r_data <= '0;
    else if (re) r_data <= mem[r_idx];
  end

  // R5: a wipe that is not overridden leaves zero behind
  a_r5_wipe_lands: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !(we && (w_idx == clr_idx))) |=> (mem[$past(clr_idx)] == '0));

  // R8: a write colliding with a pending wipe keeps its data
  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_en && we && (w_idx == clr_idx)) |=> (mem[$past(w_idx)] == $past(w_data)));
endmodule

// File: rtl/slot_pool.sv
module slot_pool #(
  parameter int SLOTS  = 32,
  parameter int DATA_W = 16,
  parameter int IDX_W  = slot_pool_pkg::slot_bits(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              rel_req,
  input  logic [IDX_W-1:0]  rel_slot,
  output logic              alloc_ack,
  output logic [IDX_W-1:0]  alloc_slot,
  output logic              rel_ack,
  output logic [DATA_W-1:0] rel_data,
  output logic              rel_err,
  output logic              pool_full,
  output logic              pool_empty
);
  localparam int CNT_W = slot_pool_pkg::count_bits(SLOTS);

  logic [IDX_W-1:0] head_idx;
  logic [CNT_W-1:0] free_cnt;
  logic             slot_busy;
  logic             alloc_go, rel_go;
  logic             clr_pend;
  logic [IDX_W-1:0] clr_slot;

  assign alloc_go = alloc_req && (free_cnt != '0);
  assign rel_go   = rel_req && slot_busy;

  slot_free_fifo #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_free (
    .clk      (clk),
    .rst      (rst),
    .pop      (alloc_go),
    .push     (rel_go),
    .push_idx (rel_slot),
    .head_idx (head_idx),
    .free_cnt (free_cnt)
  );

  slot_busy_map #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_busy (
    .clk        (clk),
    .rst        (rst),
    .set        (alloc_go),
    .set_idx    (head_idx),
    .clr        (rel_go),
    .clr_idx    (rel_slot),
    .query_idx  (rel_slot),
    .query_busy (slot_busy)
  );

  slot_store #(.SLOTS(SLOTS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (alloc_go),
    .w_idx   (head_idx),
    .w_data  (alloc_data),
    .re      (rel_go),
    .r_idx   (rel_slot),
    .r_data  (rel_data),
    .clr_en  (clr_pend),
    .clr_idx (clr_slot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_ack  <= 1'b0;
      alloc_slot <= '0;
      rel_ack    <= 1'b0;
      rel_err    <= 1'b0;
      clr_pend   <= 1'b0;
      clr_slot   <= '0;
    end else begin
      alloc_ack <= alloc_go;
      if (alloc_go) alloc_slot <= head_idx;
      rel_ack   <= rel_go;
      rel_err   <= rel_req && !slot_busy;
      clr_pend  <= rel_go;
      if (rel_go) clr_slot <= rel_slot;
    end
  end

  assign pool_full  = (free_cnt == '0);
  assign pool_empty = (free_cnt == CNT_W'(SLOTS));

  // R6: a request seen while the pool is exhausted gets no grant
  a_r6_refused_when_full: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && pool_full) |=> !alloc_ack);

  // R7: a release is either accepted or refused, never both
  a_r7_ack_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rel_ack && rel_err));

  // R10: the two status flags cannot both hold for a non-empty pool
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pool_full && pool_empty));

  // R4: every release request is answered on the next cycle
  a_r4_release_answered: assert property (@(posedge clk) disable iff (rst)
    rel_req |=> (rel_ack || rel_err));
endmodule

// File: tb/slot_pool_tb.sv
module slot_pool_tb;
  localparam int SLOTS  = 32;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              alloc_req = 1'b0;
  logic [DATA_W-1:0] alloc_data = '0;
  logic              rel_req = 1'b0;
  logic [IDX_W-1:0]  rel_slot = '0;
  logic              alloc_ack, rel_ack, rel_err, pool_full, pool_empty;
  logic [IDX_W-1:0]  alloc_slot;
  logic [DATA_W-1:0] rel_data;

  always #5 clk = ~clk;

  slot_pool #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_data(alloc_data),
    .rel_req(rel_req), .rel_slot(rel_slot),
    .alloc_ack(alloc_ack), .alloc_slot(alloc_slot),
    .rel_ack(rel_ack), .rel_data(rel_data), .rel_err(rel_err),
    .pool_full(pool_full), .pool_empty(pool_empty)
  );

  // reference model state
  int          free_q[$];
  bit          busy_m[SLOTS];
  int          mem_m[SLOTS];
  int          clr_m;
  bit          e_alloc_ack, e_rel_ack, e_rel_err;
  int          e_alloc_slot, e_rel_data;
  int          compared = 0, mismatched = 0;
  bit          done = 0;
  string       phase = "R1";

  task automatic check(string req, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s (phase %s) at %0t: got %0d expected %0d", req, phase, $time, got, exp);
    end
  endtask

  task automatic model_reset();
    free_q.delete();
    for (int i = 0; i < SLOTS; i++) begin
      free_q.push_back(i);
      busy_m[i] = 0;
      mem_m[i]  = 0;
    end
    clr_m = -1;
    e_alloc_ack = 0; e_rel_ack = 0; e_rel_err = 0;
    e_alloc_slot = 0; e_rel_data = 0;
  endtask

  // behaviour of one clock edge, from the requirements
  task automatic model_edge(bit a, int ad, bit r, int rs);
    int cnt = free_q.size();
    int widx = -1;
    int newclr = -1;
    e_alloc_ack = 0; e_rel_ack = 0; e_rel_err = 0;
    if (a && cnt > 0) begin
      widx = free_q.pop_front();
      e_alloc_ack = 1;
      e_alloc_slot = widx;
    end
    if (r) begin
      if (rs < SLOTS && busy_m[rs]) begin
        e_rel_ack = 1;
        e_rel_data = mem_m[rs];
        busy_m[rs] = 0;
        free_q.push_back(rs);
        newclr = rs;
      end else begin
        e_rel_err = 1;
      end
    end
    if (clr_m >= 0 && clr_m != widx) mem_m[clr_m] = 0;
    if (widx >= 0) begin
      mem_m[widx] = ad;
      busy_m[widx] = 1;
    end
    clr_m = newclr;
  endtask

  task automatic compare_all();
    check("R2", int'(alloc_ack), int'(e_alloc_ack));
    if (e_alloc_ack) check("R2", int'(alloc_slot), e_alloc_slot);
    check("R4", int'(rel_ack), int'(e_rel_ack));
    if (e_rel_ack) check("R4", int'(rel_data), e_rel_data);
    check("R7", int'(rel_err), int'(e_rel_err));
    check("R10", int'(pool_full), int'(free_q.size() == 0));
    check("R10", int'(pool_empty), int'(free_q.size() == SLOTS));
  endtask

  task automatic step(bit a, int ad, bit r, int rs);
    alloc_req  = a;
    alloc_data = DATA_W'(ad);
    rel_req    = r;
    rel_slot   = IDX_W'(rs);
    @(posedge clk);
    model_edge(a, ad & 16'hFFFF, r, rs);
    @(negedge clk);
    compare_all();
  endtask

  function automatic int pick_busy(int seed);
    for (int k = 0; k < SLOTS; k++) begin
      int s = (seed + k) % SLOTS;
      if (busy_m[s]) return s;
    end
    return -1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    phase = "R1";
    check("R1", int'(alloc_ack), 0);
    check("R1", int'(rel_ack), 0);
    check("R1", int'(pool_empty), 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(rel_err), 0);
    check("R1", int'(pool_full), 0);
    check("R1", int'(pool_empty), 1);

    // ascending hand-out after reset
    phase = "R2";
    for (int i = 0; i < 5; i++) begin
      step(1, 16'h1000 + i, 0, 0);
      check("R2", int'(alloc_slot), i);
    end

    // release returns stored data
    phase = "R4";
    step(0, 0, 1, 2);
    check("R4", int'(rel_data), 16'h1002);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);

    // refused releases change nothing
    phase = "R7";
    step(0, 0, 1, 2);
    step(0, 0, 1, 20);
    step(0, 0, 0, 0);

    // simultaneous allocate and release
    phase = "R9";
    step(1, 16'h2222, 1, 4);
    step(1, 16'h3333, 1, 3);

    // exhaust pool; released numbers come back after the initial ones
    phase = "R3";
    while (free_q.size() > 0) step(1, 16'h4000 + free_q.size(), 0, 0);
    phase = "R6";
    step(1, 16'hDEAD, 0, 0);
    check("R6", int'(pool_full), 1);
    step(1, 16'hBEEF, 0, 0);
    // full pool: release plus same-cycle allocate, allocation refused
    phase = "R9";
    step(1, 16'h5555, 1, 7);
    check("R9", int'(alloc_ack), 0);

    // allocate the just-freed slot while its wipe is pending
    phase = "R8";
    step(1, 16'h6A6A, 0, 0);
    check("R8", int'(alloc_slot), 7);
    step(0, 0, 1, 7);
    check("R8", int'(rel_data), 16'h6A6A);
    phase = "R5";
    step(1, 16'h0777, 0, 0);
    step(0, 0, 1, 7);
    check("R5", int'(rel_data), 16'h0777);

    // drain everything
    phase = "R10";
    for (int s = 0; s < SLOTS; s++) if (busy_m[s]) step(0, 0, 1, s);
    step(0, 0, 0, 0);
    check("R10", int'(pool_empty), 1);

    // random mixed traffic
    phase = "mix";
    for (int n = 0; n < 3000; n++) begin
      int rv = $urandom;
      bit a = rv[0] | rv[1];
      bit r = rv[2] | rv[3];
      int rs = rv[4] ? pick_busy(rv[15:8]) : (rv[20:16] % SLOTS);
      if (rs < 0) rs = rv[20:16] % SLOTS;
      step(a, rv[31:16], r, rs);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule